// File: doc/BRIEF.md
# Serial Baud Enable Chain

This block turns the internal bus clock into the two timing strobes that a serial transmitter and receiver need. A prescaler with a choice of non-binary ratios (1, 3, 4, 13 and, when enabled by a parameter, 39) feeds a binary rate stage that divides by 2^N. The result is the 16x receiver sampling strobe. A last stage divides that strobe by sixteen to give the 1x bit-rate strobe for the transmitter. Both outputs are enables one bus clock wide, not derived clocks, so every consumer stays in the bus clock domain.

The prescaler code and the rate exponent are loaded together through a write strobe. A load restarts all three counters from zero, so no short or merged pulse can appear on either output. Reset clears the prescaler code to the divide-by-one setting but keeps the rate exponent, so software that set the rate once need not set it again after a reset. There is no state machine: the chain is three modulo counters, each advanced by the strobe of the stage before it. The states of a counter are its count values, and its one transition is either an advance or a wrap to zero.

Top module: `baud_enable_chain`

## Requirements
- R1: Prescaler codes 3'b000, 3'b001, 3'b010 and 3'b011 divide by 1, 3, 4 and 13.
- R2: With EXT_PRESC=1, any code with bit 2 set divides by 39. With EXT_PRESC=0, bit 2 is ignored.
- R3: A rate exponent N (0 to 7) divides further by 2^N. `rt_tick` therefore repeats every P*2^N bus cycles, where P is the prescale ratio.
- R4: `bit_tick` is high on every sixteenth `rt_tick` and only in a cycle where `rt_tick` is also high.
- R5: When the period P*2^N is above 1, each strobe is high for exactly one cycle.
- R6: A load (`cfg_we` high at an edge) clears all counters. Both strobes are low in the cycle after that edge. The first `rt_tick` comes P*2^N cycles after the load edge, and the first `bit_tick` comes 16*P*2^N cycles after it.
- R7: While reset is low, both strobes are low. Reset sets the prescaler code to 3'b000 and leaves the rate exponent unchanged. Counting starts from zero at the last reset edge.
- R8: Changes on `cfg_presc` and `cfg_rate` without `cfg_we` have no effect on the strobes. A load is also ignored while reset is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load strobe for both configuration fields |
| cfg_presc | input | 3 | Prescaler code; bit 2 is the extended setting |
| cfg_rate | input | RATE_BITS | Rate exponent N |
| rt_tick | output | 1 | 16x receiver sampling enable |
| bit_tick | output | 1 | 1x bit-rate enable |

## Verification
After a load edge or the last reset edge, the bench counts bus cycles c. It expects `rt_tick` high exactly when c is a nonzero multiple of P*2^N, and `bit_tick` high exactly when c is a nonzero multiple of 16*P*2^N. This accounts for the one output register that follows the combinational hit of each counter. Each sample is taken at the falling edge after the counted rising edge, and the value at c=0 is checked as the quiet cycle after a load. Pattern windows cover two full bit periods for short settings, and are capped for long settings. Configuration data is shuffled without the strobe during the windows.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int PRE_MAX = 39;
    localparam int PRE_W   = $clog2(PRE_MAX);

    typedef enum logic [2:0] {
        PS_DIV1  = 3'b000,
        PS_DIV3  = 3'b001,
        PS_DIV4  = 3'b010,
        PS_DIV13 = 3'b011,
        PS_DIV39 = 3'b100
    } presc_code_e;

    // terminal count of the prescaler (ratio minus one)
    function automatic logic [PRE_W-1:0] presc_last(input logic [2:0] code);
        logic [PRE_W-1:0] r;
        if (code[2]) r = PRE_W'(PRE_MAX - 1);
        else begin
            unique case (presc_code_e'(code))
                PS_DIV1:  r = PRE_W'(0);
                PS_DIV3:  r = PRE_W'(2);
                PS_DIV4:  r = PRE_W'(3);
                PS_DIV13: r = PRE_W'(12);
                default:  r = PRE_W'(0);
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] last,
    output logic         hit
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (clr)     cnt <= '0;
        else if (adv)     cnt <= (cnt == last) ? '0 : cnt + W'(1);
    end

    assign hit = adv && (cnt == last);

    // R3: a counter never runs past the terminal count it was cleared for
    p_count_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last);
endmodule

// File: rtl/baud_enable_chain.sv
module baud_enable_chain
    import baud_pkg::*;
#(
    parameter int EXT_PRESC  = 1,
    parameter int RATE_BITS  = 3,
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_presc,
    input  logic [RATE_BITS-1:0] cfg_rate,
    output logic                 rt_tick,
    output logic                 bit_tick
);
    localparam int RATE_CW = (1 << RATE_BITS) - 1;
    localparam int BIT_W   = $clog2(OVERSAMPLE);

    logic [2:0]           presc_q;
    logic [RATE_BITS-1:0] rate_q;
    logic                 load;
    logic                 pre_hit, rt_hit, bit_hit;
    logic [PRE_W-1:0]     pre_last;
    logic [RATE_CW-1:0]   rate_last;
    logic [2:0]           presc_in;

    generate
        if (EXT_PRESC != 0) begin : g_ext
            assign presc_in = cfg_presc;
        end else begin : g_base
            assign presc_in = {1'b0, cfg_presc[1:0]};
        end
    endgenerate

    assign load = cfg_we && rst_n;

    always_ff @(posedge clk) begin
        if (!rst_n)    presc_q <= PS_DIV1;
        else if (load) presc_q <= presc_in;
    end

    // rate exponent keeps its value through reset
    always_ff @(posedge clk) begin
        if (load) rate_q <= cfg_rate;
    end

    assign pre_last  = presc_last(presc_q);
    assign rate_last = {RATE_CW{1'b1}} >> (RATE_CW - int'(rate_q));

    tick_counter #(.W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(load), .adv(1'b1),
        .last(pre_last), .hit(pre_hit));

    tick_counter #(.W(RATE_CW)) u_rate (
        .clk(clk), .rst_n(rst_n), .clr(load), .adv(pre_hit),
        .last(rate_last), .hit(rt_hit));

    tick_counter #(.W(BIT_W)) u_bit (
        .clk(clk), .rst_n(rst_n), .clr(load), .adv(rt_hit),
        .last(BIT_W'(OVERSAMPLE - 1)), .hit(bit_hit));

    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            rt_tick  <= 1'b0;
            bit_tick <= 1'b0;
        end else begin
            rt_tick  <= rt_hit;
            bit_tick <= bit_hit;
        end
    end

    // R4: the 1x strobe only appears together with a 16x strobe
    p_bit_in_rt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> rt_tick);

    // R5: strobes are one cycle wide unless the whole period is one cycle
    p_single_rt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_tick && !(pre_last == '0 && rate_last == '0)) |=> !rt_tick);

    p_single_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

    // R6: the cycle after a load is quiet on both strobes
    p_quiet_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (!rt_tick && !bit_tick));

    // R7: leaving reset, the prescaler sits at divide-by-one
    p_presc_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (presc_q == 3'b000));

    // R8: the rate exponent moves only on a load
    p_rate_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(rate_q));
endmodule

// File: tb/baud_enable_chain_tb_top.sv
module baud_enable_chain_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_presc = 3'b000;
    logic [2:0] cfg_rate = 3'b000;
    logic       rt_tick, bit_tick;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    baud_enable_chain dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_presc(cfg_presc),
        .cfg_rate(cfg_rate), .rt_tick(rt_tick), .bit_tick(bit_tick));

    function automatic int ratio(input logic [2:0] code);
        if (code[2]) return 39;
        case (code[1:0])
            2'd0: return 1;
            2'd1: return 3;
            2'd2: return 4;
            default: return 13;
        endcase
    endfunction

    function automatic int period(input logic [2:0] code, input logic [2:0] n);
        return ratio(code) * (1 << n);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] p, input logic [2:0] n);
        @(negedge clk);
        cfg_we = 1'b1; cfg_presc = p; cfg_rate = n;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // called at the falling edge right after the start edge (c = 0)
    task automatic run_check(input int d, input int len, input bit jitter, input string req);
        int bad = 0, first_c = -1, act = 0, expv = 0;
        check(rt_tick == 1'b0 && bit_tick == 1'b0, {req, " quiet start"},
              {30'd0, rt_tick, bit_tick}, 0);
        for (int c = 1; c <= len; c++) begin
            @(posedge clk);
            @(negedge clk);
            begin
                int e = ((c % d) == 0) ? 2 : 0;
                int a;
                e += ((c % (16 * d)) == 0) ? 1 : 0;
                a = {30'd0, rt_tick, bit_tick};
                if (a != e) begin
                    bad++;
                    if (first_c < 0) begin first_c = c; act = a; expv = e; end
                end
            end
            if (jitter) begin
                cfg_presc = 3'($urandom);
                cfg_rate  = 3'($urandom);
            end
        end
        if (bad != 0)
            $display("  first mismatch at cycle %0d of period %0d", first_c, d);
        check(bad == 0, req, act, expv);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=0", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        // R7: strobes low during reset, a load during reset is ignored (R8)
        repeat (2) @(negedge clk);
        cfg_we = 1'b1; cfg_presc = 3'b011; cfg_rate = 3'd4;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        check(rt_tick == 0 && bit_tick == 0, "R7 reset outputs", {30'd0, rt_tick, bit_tick}, 0);

        @(negedge clk); rst_n = 1'b1;
        // R1: each base prescaler code, rate 0
        for (int p = 0; p < 4; p++) begin
            load(3'(p), 3'd0);
            run_check(period(3'(p), 3'd0), 32 * period(3'(p), 3'd0) + 3, 1'b0, "R1 base prescale");
        end
        // R2: extended codes
        load(3'b100, 3'd0);
        run_check(39, 2 * 16 * 39 + 3, 1'b0, "R2 code 100");
        load(3'b111, 3'd1);
        run_check(78, 16 * 78 + 3, 1'b0, "R2 code 111");
        // R3: longest period, rt strobes only
        load(3'b100, 3'd7);
        run_check(39 * 128, 2 * 39 * 128 + 5, 1'b0, "R3 max period");
        // R3/R4/R5: random settings
        for (int i = 0; i < 20; i++) begin
            logic [2:0] p = 3'($urandom);
            logic [2:0] n = 3'($urandom);
            int d = period(p, n);
            int len = (32 * d + 3 > 2500) ? 2500 : 32 * d + 3;
            load(p, n);
            run_check(d, len, 1'b0, "R3 R4 R5 random");
        end
        // R6: reload part way through a period
        load(3'b010, 3'd2);
        repeat (7) @(negedge clk);
        load(3'b001, 3'd1);
        run_check(6, 200, 1'b0, "R6 reload mid period");
        // R8: data lines shuffled without the strobe
        load(3'b011, 3'd0);
        run_check(13, 16 * 13 * 2 + 3, 1'b1, "R8 data ignored");
        // R7: rate kept, prescaler back to divide-by-one
        load(3'b001, 3'd2);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(rt_tick == 0 && bit_tick == 0, "R7 outputs in reset", {30'd0, rt_tick, bit_tick}, 0);
        rst_n = 1'b1;
        run_check(4, 16 * 4 * 2 + 3, 1'b0, "R7 rate survives reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule